// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from fourteen maskable sources and presents the single most urgent one to a processor core as a pending flag plus a 16-bit vector address. Each source owns one request bit and one enable bit. Peripheral sources (timers, serial links, video sync and similar) arrive as one-cycle pulses. Two sources come from external pins, each with its own selectable active edge.

Software reaches the request, enable and edge-polarity state through a small byte-wide register port. A request bit can be cleared from software but never set. The core supplies its interrupt-disable flag and a software-break request. When the core takes the interrupt, it pulses an accept strobe. The block then drops the serviced request bit and tells the core to raise its disable flag. While reset is asserted, the vector output shows the reset vector. The software break sits below every maskable source and ignores both the enables and the disable flag.

Top module: `irq_ctrl`

## Requirements
- R1: `irq_o` is high when some source has both its request bit and its enable bit set while `idis_i` is 0, or when `brk_i` is 1; otherwise it is low.
- R2: Among live maskable sources, the lowest source index wins. For winning index i (0 to 13), `vec_o` is FFFC hex minus 2·i, so index 0 gives FFFC and index 13 gives FFE2. With nothing pending, `vec_o` is 0000.
- R3: When `ack_i` is high while a maskable source wins, that source's request bit is 0 after the clock edge. `set_idis_o` is high whenever `ack_i` and `irq_o` are both high.
- R4: Writing a 0 to a request bit clears it, and writing a 1 leaves it unchanged. Enable bits take the written value, whether 0 or 1.
- R5: While `rst` is high, `vec_o` is FFFE hex. After reset, all request, enable and polarity bits read 0.
- R6: When `brk_i` is high and no maskable source is live, `vec_o` is FFDE hex, whatever the value of `idis_i`. Accepting the break changes no request bit.
- R7: Polarity bit 0 selects the edge for pin 0 and bit 1 for pin 1. A value of 0 selects the rising edge and 1 the falling edge. Pin 0 sets request index 1 and pin 1 sets request index 11. The request bit reads 1 from the third rising clock edge after the pin changes, and the opposite edge sets nothing.
- R8: When a hardware set of a request bit falls in the same cycle as a software clear or an accept clear of that bit, the bit ends up set.
- R9: Bits 1 and 11 of `periph_pulse_i` are ignored, because those indices belong to the external pins.
- R10: The register map, with 8-bit data, is as follows. Address 0 holds request bits for indices 7..0. Address 1 holds request bits for indices 13..8 in bits 5..0. Address 2 holds enable bits for indices 7..0. Address 3 holds enable bits for indices 13..8. Address 4 holds the polarity bits in bits 1..0. Unused bits and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for write and read |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| ext_pin_i | input | 2 | Asynchronous external interrupt pins |
| periph_pulse_i | input | 14 | One-cycle request pulses from peripherals |
| idis_i | input | 1 | Interrupt-disable flag from the core |
| brk_i | input | 1 | Software-break request from the core |
| ack_i | input | 1 | Accept strobe from the core |
| irq_o | output | 1 | Interrupt pending toward the core |
| vec_o | output | 16 | Vector address of the winning request |
| set_idis_o | output | 1 | Tells the core to set its disable flag |

## Verification
The functions that can collide in one cycle are the hardware setting of a request bit and the clearing of that same bit, either by a software write of 0 or by an accept strobe. The bench provokes this by raising a peripheral pulse on the same negative clock edge where it drives a zero write to the request register. In a second case, it raises the pulse on the same edge as the accept strobe for the winning source. The bench judges both cases by reading the request register back through the port after the edge and expecting the bit to still be 1.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;

    localparam int NUM_SRC = 14;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int VEC_W   = 16;
    localparam int NUM_EXT = 2;
    localparam int IDX_W   = $clog2(NUM_SRC);

    localparam logic [VEC_W-1:0] VEC_RESET        = 16'hFFFE;
    localparam logic [VEC_W-1:0] VEC_TOP_MASKABLE = 16'hFFFC;
    localparam logic [VEC_W-1:0] VEC_BREAK        = 16'hFFDE;
    localparam logic [VEC_W-1:0] VEC_IDLE         = 16'h0000;

    // request index driven by each external pin
    localparam int EXT_POS [NUM_EXT] = '{1, 11};

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } grant_t;

    typedef enum logic [1:0] {
        VK_NONE,
        VK_RESET,
        VK_MASKABLE,
        VK_BREAK
    } vec_kind_e;

    function automatic logic [VEC_W-1:0] maskable_vec(input logic [IDX_W-1:0] idx);
        return VEC_TOP_MASKABLE - VEC_W'({idx, 1'b0});
    endfunction

    function automatic logic [NUM_SRC-1:0] ext_mask();
        logic [NUM_SRC-1:0] m;
        m = '0;
        for (int e = 0; e < NUM_EXT; e++) m[EXT_POS[e]] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_edge_sync.sv
`timescale 1ns/1ps
module irq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;
    logic              cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign cur    = sync_q[STAGES-1];
    assign edge_o = fall_sel_i ? (last_q & ~cur) : (~last_q & cur);

endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
    import irq_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NE = NUM_EXT
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_wr_t       wr_i,
    input  logic [N-1:0]  hw_set_i,
    input  logic [N-1:0]  ack_clr_i,
    output logic [N-1:0]  req_o,
    output logic [N-1:0]  en_o,
    output logic [NE-1:0] pol_o,
    output logic [DW-1:0] rdata_o
);
    localparam int NB = (N + DW - 1) / DW;
    localparam int PW = NB * DW;

    logic [N-1:0]  req_q, en_q;
    logic [NE-1:0] pol_q;
    logic [PW-1:0] sw_clr, en_we, en_wv;
    logic [PW-1:0] req_pad, en_pad;

    always_comb begin
        sw_clr = '0;
        en_we  = '0;
        en_wv  = '0;
        for (int b = 0; b < NB; b++) begin
            if (wr_i.we && wr_i.addr == AW'(b))
                sw_clr[b*DW +: DW] = ~wr_i.data;
            if (wr_i.we && wr_i.addr == AW'(NB + b)) begin
                en_we[b*DW +: DW] = '1;
                en_wv[b*DW +: DW] = wr_i.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            en_q  <= '0;
            pol_q <= '0;
        end else begin
            // hardware set is applied last so it beats any clear
            req_q <= (req_q & ~sw_clr[N-1:0] & ~ack_clr_i) | hw_set_i;
            en_q  <= (en_q & ~en_we[N-1:0]) | (en_wv[N-1:0] & en_we[N-1:0]);
            if (wr_i.we && wr_i.addr == AW'(2 * NB))
                pol_q <= wr_i.data[NE-1:0];
        end
    end

    assign req_pad = PW'(req_q);
    assign en_pad  = PW'(en_q);

    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < NB; b++) begin
            if (wr_i.addr == AW'(b))      rdata_o = req_pad[b*DW +: DW];
            if (wr_i.addr == AW'(NB + b)) rdata_o = en_pad[b*DW +: DW];
        end
        if (wr_i.addr == AW'(2 * NB)) rdata_o = DW'(pol_q);
    end

    assign req_o = req_q;
    assign en_o  = en_q;
    assign pol_o = pol_q;

endmodule

// File: rtl/irq_prio.sv
`timescale 1ns/1ps
module irq_prio
    import irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic             rst,
    input  logic [N-1:0]     req_i,
    input  logic [N-1:0]     en_i,
    input  logic             idis_i,
    input  logic             brk_i,
    output grant_t           grant_o,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o
);
    logic [N-1:0] live;
    grant_t       g;
    vec_kind_e    kind;

    assign live = req_i & en_i & {N{~idis_i}};

    always_comb begin
        g = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i]) begin
                g.hit = 1'b1;
                g.idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (rst)        kind = VK_RESET;
        else if (g.hit) kind = VK_MASKABLE;
        else if (brk_i) kind = VK_BREAK;
        else            kind = VK_NONE;
    end

    always_comb begin
        unique case (kind)
            VK_RESET:    vec_o = VEC_RESET;
            VK_MASKABLE: vec_o = maskable_vec(g.idx);
            VK_BREAK:    vec_o = VEC_BREAK;
            default:     vec_o = VEC_IDLE;
        endcase
    end

    assign grant_o = g;
    assign irq_o   = g.hit | brk_i;

endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int N           = NUM_SRC,
    parameter int DW          = DATA_W,
    parameter int AW          = ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we_i,
    input  logic [AW-1:0]      reg_addr_i,
    input  logic [DW-1:0]      reg_wdata_i,
    output logic [DW-1:0]      reg_rdata_o,
    input  logic [NUM_EXT-1:0] ext_pin_i,
    input  logic [N-1:0]       periph_pulse_i,
    input  logic               idis_i,
    input  logic               brk_i,
    input  logic               ack_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               set_idis_o
);
    localparam logic [N-1:0] EXT_MASK = N'(ext_mask());

    bus_wr_t            wr;
    logic [NUM_EXT-1:0] pol, ext_edge;
    logic [N-1:0]       req_q, en_q, hw_set, ack_clr;
    grant_t             win;

    assign wr = '{we: reg_we_i, addr: reg_addr_i, data: reg_wdata_i};

    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
        irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk        (clk),
            .rst        (rst),
            .pin_i      (ext_pin_i[e]),
            .fall_sel_i (pol[e]),
            .edge_o     (ext_edge[e])
        );
    end

    always_comb begin
        hw_set = periph_pulse_i & ~EXT_MASK;
        for (int e = 0; e < NUM_EXT; e++)
            hw_set[EXT_POS[e]] = ext_edge[e];
    end

    assign ack_clr = (ack_i && win.hit) ? (N'(1) << win.idx) : '0;

    irq_regs #(.N(N), .DW(DW), .AW(AW), .NE(NUM_EXT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr),
        .hw_set_i  (hw_set),
        .ack_clr_i (ack_clr),
        .req_o     (req_q),
        .en_o      (en_q),
        .pol_o     (pol),
        .rdata_o   (reg_rdata_o)
    );

    irq_prio #(.N(N)) u_prio (
        .rst     (rst),
        .req_i   (req_q),
        .en_i    (en_q),
        .idis_i  (idis_i),
        .brk_i   (brk_i),
        .grant_o (win),
        .irq_o   (irq_o),
        .vec_o   (vec_o)
    );

    assign set_idis_o = ack_i & irq_o;

endmodule

// File: rtl/irq_ctrl_chk.sv
`timescale 1ns/1ps
module irq_ctrl_chk
    import irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input logic             clk,
    input logic             rst,
    input logic             idis_i,
    input logic             brk_i,
    input logic             ack_i,
    input logic             irq_o,
    input logic [VEC_W-1:0] vec_o,
    input logic [N-1:0]     req_q,
    input logic [N-1:0]     hw_set,
    input grant_t           win
);
    // R1: disable flag masks every maskable source
    p_idis_masks_r1: assert property (@(posedge clk) disable iff (rst)
        (idis_i && !brk_i) |-> !irq_o);

    // R3: an accepted maskable request is gone after the edge
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (ack_i && win.hit && !hw_set[win.idx]) |=> !req_q[$past(win.idx)]);

    // R4: no request bit rises without a hardware set
    p_no_sw_set_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((req_q & ~$past(req_q) & ~$past(hw_set)) == '0));

    // R8: a hardware set always lands
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((req_q & $past(hw_set)) == $past(hw_set)));

    // R6: break vector when no maskable source is live
    p_brk_vec_r6: assert property (@(posedge clk) disable iff (rst)
        (brk_i && !win.hit) |-> (vec_o == VEC_BREAK && irq_o));

    // R5: reset vector while reset is held
    always @(posedge clk) begin
        if (rst) begin
            p_reset_vec_r5: assert (vec_o == VEC_RESET);
        end
    end
endmodule

bind irq_ctrl irq_ctrl_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .idis_i (idis_i),
    .brk_i  (brk_i),
    .ack_i  (ack_i),
    .irq_o  (irq_o),
    .vec_o  (vec_o),
    .req_q  (req_q),
    .hw_set (hw_set),
    .win    (win)
);

// File: tb/tb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctrl;

    typedef struct packed {
        logic [13:0] en;
        logic [13:0] pulse;
        logic        idis;
        logic        brk;
        logic        irq;
        logic [15:0] vec;
    } row_t;

    // R1 R2 R6 R9 table: enables, pulses, flags, expected irq and vector
    localparam row_t ROWS [9] = '{
        '{14'h3FFF, 14'h0001, 1'b0, 1'b0, 1'b1, 16'hFFFC},
        '{14'h3FFF, 14'h3000, 1'b0, 1'b0, 1'b1, 16'hFFE4},
        '{14'h2000, 14'h3000, 1'b0, 1'b0, 1'b1, 16'hFFE2},
        '{14'h3FFF, 14'h0000, 1'b0, 1'b1, 1'b1, 16'hFFDE},
        '{14'h3FFF, 14'h0020, 1'b1, 1'b0, 1'b0, 16'h0000},
        '{14'h3FFF, 14'h0020, 1'b1, 1'b1, 1'b1, 16'hFFDE},
        '{14'h0000, 14'h37FD, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{14'h3FFF, 14'h0802, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{14'h0FF0, 14'h0F0F, 1'b0, 1'b0, 1'b1, 16'hFFEC}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [1:0]  pin = '0;
    logic [13:0] pulse = '0;
    logic        idis = 1'b0, brk = 1'b0, ack = 1'b0;
    logic        irq, set_idis;
    logic [15:0] vec;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_ctrl dut (
        .clk(clk), .rst(rst), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ext_pin_i(pin),
        .periph_pulse_i(pulse), .idis_i(idis), .brk_i(brk), .ack_i(ack),
        .irq_o(irq), .vec_o(vec), .set_idis_o(set_idis)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic clr_all();
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
    endtask

    task automatic pulse_once(input logic [13:0] p);
        @(negedge clk); pulse = p;
        @(negedge clk); pulse = '0;
    endtask

    task automatic apply_row(input row_t r, input int k);
        clr_all();
        wr(3'd2, r.en[7:0]);
        wr(3'd3, {2'b00, r.en[13:8]});
        @(negedge clk); pulse = r.pulse;
        @(negedge clk); pulse = '0; idis = r.idis; brk = r.brk;
        #1;
        chk(irq == r.irq, $sformatf("R1 row %0d irq", k), 32'(irq), 32'(r.irq));
        chk(vec == r.vec, $sformatf("R2 row %0d vec", k), 32'(vec), 32'(r.vec));
        idis = 1'b0; brk = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        #1;
        chk(vec == 16'hFFFE, "R5 reset vector", 32'(vec), 32'hFFFE);
        @(negedge clk); rst = 1'b0;
        rd(3'd0, d); chk(d == 8'h00, "R5 req lo after reset", 32'(d), 0);
        rd(3'd3, d); chk(d == 8'h00, "R5 en hi after reset", 32'(d), 0);
        rd(3'd4, d); chk(d == 8'h00, "R7 polarity after reset", 32'(d), 0);
        chk(irq == 1'b0, "R1 idle after reset", 32'(irq), 0);

        for (int k = 0; k < 9; k++) apply_row(ROWS[k], k);

        // R4 software write rules and R10 map
        clr_all();
        pulse_once(14'h0008);
        wr(3'd0, 8'hFF); rd(3'd0, d); chk(d == 8'h08, "R4 write one keeps", 32'(d), 32'h08);
        wr(3'd0, 8'hF7); rd(3'd0, d); chk(d == 8'h00, "R4 write zero clears", 32'(d), 0);
        wr(3'd0, 8'hFF); rd(3'd0, d); chk(d == 8'h00, "R4 write one no set", 32'(d), 0);
        wr(3'd2, 8'hA5); rd(3'd2, d); chk(d == 8'hA5, "R4 enable write", 32'(d), 32'hA5);
        wr(3'd2, 8'h5A); rd(3'd2, d); chk(d == 8'h5A, "R4 enable rewrite", 32'(d), 32'h5A);
        wr(3'd3, 8'hFF); rd(3'd3, d); chk(d == 8'h3F, "R10 en hi unused bits", 32'(d), 32'h3F);
        rd(3'd6, d); chk(d == 8'h00, "R10 unused address", 32'(d), 0);

        // R3 accept clears the winner
        wr(3'd2, 8'hFF);
        clr_all();
        @(negedge clk); pulse = 14'h0044;
        @(negedge clk); pulse = '0; #1;
        chk(vec == 16'hFFF8, "R2 winner index 2", 32'(vec), 32'hFFF8);
        ack = 1'b1; #1;
        chk(set_idis == 1'b1, "R3 set_idis on accept", 32'(set_idis), 1);
        @(negedge clk); ack = 1'b0; #1;
        chk(vec == 16'hFFF0, "R3 next winner index 6", 32'(vec), 32'hFFF0);
        rd(3'd0, d); chk(d == 8'h40, "R3 serviced bit cleared", 32'(d), 32'h40);

        // R6 break accept touches no request bit
        clr_all();
        wr(3'd2, 8'h00);
        pulse_once(14'h0008);
        @(negedge clk); brk = 1'b1; idis = 1'b1; ack = 1'b1; #1;
        chk(vec == 16'hFFDE, "R6 break vector masked", 32'(vec), 32'hFFDE);
        chk(set_idis == 1'b1, "R3 set_idis on break", 32'(set_idis), 1);
        @(negedge clk); brk = 1'b0; idis = 1'b0; ack = 1'b0;
        rd(3'd0, d); chk(d == 8'h08, "R6 break keeps requests", 32'(d), 32'h08);

        // R8 set beats software clear and accept clear
        clr_all();
        wr(3'd2, 8'hFF);
        @(negedge clk); pulse = 14'h0010; we = 1'b1; addr = 3'd0; wdata = 8'h00;
        @(negedge clk); pulse = '0; we = 1'b0;
        rd(3'd0, d); chk(d == 8'h10, "R8 set beats sw clear", 32'(d), 32'h10);
        pulse_once(14'h0001);
        @(negedge clk); ack = 1'b1; pulse = 14'h0001;
        @(negedge clk); ack = 1'b0; pulse = '0;
        rd(3'd0, d); chk(d == 8'h11, "R8 set beats accept clear", 32'(d), 32'h11);

        // R7 external edges
        clr_all();
        @(negedge clk); addr = 3'd0; pin[0] = 1'b1;
        @(negedge clk); @(negedge clk); #1;
        chk(rdata[1] == 1'b0, "R7 not yet set at edge 2", 32'(rdata[1]), 0);
        @(negedge clk); #1;
        chk(rdata[1] == 1'b1, "R7 rising sets index 1", 32'(rdata[1]), 1);
        clr_all();
        @(negedge clk); pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        rd(3'd0, d); chk(d == 8'h00, "R7 falling ignored pol 0", 32'(d), 0);
        wr(3'd4, 8'h01); rd(3'd4, d); chk(d == 8'h01, "R7 polarity readback", 32'(d), 1);
        @(negedge clk); pin[0] = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd0, d); chk(d == 8'h00, "R7 rising ignored pol 1", 32'(d), 0);
        @(negedge clk); pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        rd(3'd0, d); chk(d == 8'h02, "R7 falling sets pol 1", 32'(d), 32'h02);
        clr_all();
        @(negedge clk); pin[1] = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd1, d); chk(d == 8'h08, "R7 pin 1 sets index 11", 32'(d), 32'h08);

        finish_run();
    end

endmodule